// File: doc/BRIEF.md
# Parallel Flash Programming Mode Controller

This block lets an external programmer reach an on-chip flash array through the device's parallel ports. The controller detects host mode from the reset and program-store-enable pins. It keeps the CPU core in reset and enables the internal oscillator for as long as the device stays in that mode. No other command is accepted until the host has armed the controller by holding the Read-ID command code for a set number of oscillator cycles.

Once armed, the controller decodes a command code from the upper bits of two ports. It builds a 16-bit address from three ports. A falling edge on the program strobe starts a byte-program, a row-wide burst-program or a byte-verify on the flash array interface. A ready/busy output stays low while a write runs. A per-block lock vector blocks both program and verify commands aimed at a protected block. Every pin is passed through a two-flop synchroniser before any decision is made.

Top module: `pflash_host_ctrl`

## Requirements
- R1: Out of reset, all outputs are inactive. Host mode begins when the synchronised reset pin is high and the store-enable pin is low, and it ends when the reset pin goes low. `cpu_rst_o` is high whenever the reset pin is high or host mode is active. `osc_en` is high exactly while host mode is active.
- R2: The address is {p3_hi[1:0], p2_in[5:0], p1_in[7:0]}. Write data is taken from p0_in.
- R3: The command code is {p3_hi[3:2], p2_in[7:6]}. 4'b1110 is byte-program, 4'b0110 is burst-program, 4'b1100 is byte-verify and 4'b0000 is Read-ID. Every other code does nothing.
- R4: After host mode entry, program and verify strobes are ignored until the Read-ID code has been held for ARM_CYCLES consecutive cycles. Any other code seen before that count is reached restarts the count from zero.
- R5: The block index is the top log2(LOCK_BLKS) address bits. When blk_lock at that index is high, a program strobe writes nothing and leaves rdy_busy_n high, and a verify strobe leaves p0_oe low.
- R6: A burst-program writes ROW_BYTES consecutive bytes, starting at the address with its low log2(ROW_BYTES) bits cleared. Each byte takes data from p0_in at the moment it is written, and the write stays inside that row.
- R7: An accepted program strobe (falling edge) drives rdy_busy_n low for BUSY_CYCLES per byte written. fl_we is high for exactly one cycle at the start of each byte.
- R8: A strobe edge that arrives while rdy_busy_n is low is ignored.
- R9: Leaving host mode clears the armed state, so the host must arm again after it re-enters host mode.
- R10: An accepted byte-verify reads the flash at the assembled address and presents the byte on p0_out with p0_oe high. The data stays there until the command code changes, a new strobe is accepted, or host mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_rst | input | 1 | Device reset pin |
| pin_psen_n | input | 1 | Program-store-enable pin, active low |
| pin_strobe_n | input | 1 | Program strobe pin, falling edge starts an operation |
| p0_in | input | 8 | Port 0 input, write data |
| p1_in | input | 8 | Port 1 input, address low byte |
| p2_in | input | 8 | Port 2 input, address bits 13:8 and command bits |
| p3_hi | input | 4 | Port 3 bits 7:4, command bits and address bits 15:14 |
| blk_lock | input | LOCK_BLKS | Per-block security lock |
| fl_rdata | input | 8 | Flash array read data |
| p0_out | output | 8 | Verify data out on port 0 |
| p0_oe | output | 1 | Port 0 output enable |
| rdy_busy_n | output | 1 | Ready (high) / busy (low) |
| cpu_rst_o | output | 1 | CPU core reset |
| osc_en | output | 1 | Internal oscillator enable |
| fl_addr | output | 16 | Flash array address |
| fl_wdata | output | 8 | Flash array write data |
| fl_we | output | 1 | Flash array write enable, one cycle per byte |
| fl_re | output | 1 | Flash array read enable |

## Verification
The bench builds the controller with ARM_CYCLES=20, BUSY_CYCLES=8, ROW_BYTES=4 and LOCK_BLKS=4. With these values, an interrupted arming hold and a complete one both fit within a few dozen cycles. Every cycle of a busy period can be counted, and a whole burst row can be compared byte by byte, along with the first byte past the row. Four lock blocks let a locked block and an unlocked block be used side by side in the same run.

// File: rtl/pfh_pkg.sv
package pfh_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_BYTE   = 2'd1,
    OP_BURST  = 2'd2,
    OP_VERIFY = 2'd3
  } op_e;

  // code = {P3[7:6], P2[7:6]}
  function automatic op_e decode_op(input logic [3:0] code);
    case (code)
      4'b1110: decode_op = OP_BYTE;
      4'b0110: decode_op = OP_BURST;
      4'b1100: decode_op = OP_VERIFY;
      default: decode_op = OP_NONE;
    endcase
  endfunction

  function automatic logic is_read_id(input logic [3:0] code);
    is_read_id = (code == 4'b0000);
  endfunction

endpackage

// File: rtl/pfh_sync.sv
module pfh_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/pfh_arm.sv
module pfh_arm #(
  parameter int ARM_CYCLES = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host,
  input  logic read_id,
  output logic armed
);

  localparam int CW = $clog2(ARM_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(ARM_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (!host) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (!armed_q) begin
      if (read_id) begin
        if (cnt_q == CNT_LAST) begin
          armed_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

endmodule

// File: rtl/pfh_seq.sv
module pfh_seq
  import pfh_pkg::*;
#(
  parameter int BUSY_CYCLES = 640,
  parameter int ROW_BYTES   = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  op_e         op,
  input  logic [15:0] addr_in,
  input  logic        vclear,
  input  logic [7:0]  fl_rdata,
  output logic        busy,
  output logic        fl_we,
  output logic        fl_re,
  output logic [15:0] fl_addr,
  output logic [7:0]  vdata,
  output logic        vvalid
);

  localparam int YW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam int BW = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;
  localparam logic [YW-1:0] CYC_LAST  = YW'(BUSY_CYCLES - 1);
  localparam logic [BW-1:0] BYTE_LAST = BW'(ROW_BYTES - 1);
  localparam logic [15:0]   ROW_MASK  = ~16'(ROW_BYTES - 1);

  logic          busy_q, busy_d;
  logic          burst_q, burst_d;
  logic [YW-1:0] cyc_q, cyc_d;
  logic [BW-1:0] byte_q, byte_d;
  logic [15:0]   addr_q, addr_d;
  logic          re_q, re_d;
  logic [7:0]    vdata_q, vdata_d;
  logic          vvalid_q, vvalid_d;

  always_comb begin
    busy_d   = busy_q;
    burst_d  = burst_q;
    cyc_d    = cyc_q;
    byte_d   = byte_q;
    addr_d   = addr_q;
    re_d     = 1'b0;
    vdata_d  = vdata_q;
    vvalid_d = vvalid_q;

    if (busy_q) begin
      if (cyc_q == CYC_LAST) begin
        if (burst_q && (byte_q != BYTE_LAST)) begin
          byte_d = byte_q + 1'b1;
          cyc_d  = '0;
          addr_d = addr_q + 16'd1;
        end else begin
          busy_d = 1'b0;
        end
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end else if (start) begin
      case (op)
        OP_BYTE: begin
          busy_d  = 1'b1;
          burst_d = 1'b0;
          cyc_d   = '0;
          byte_d  = '0;
          addr_d  = addr_in;
        end
        OP_BURST: begin
          busy_d  = 1'b1;
          burst_d = 1'b1;
          cyc_d   = '0;
          byte_d  = '0;
          addr_d  = addr_in & ROW_MASK;
        end
        OP_VERIFY: begin
          re_d   = 1'b1;
          addr_d = addr_in;
        end
        default: ;
      endcase
    end

    if (start || vclear) begin
      vvalid_d = 1'b0;
    end
    if (re_q) begin
      vvalid_d = 1'b1;
      vdata_d  = fl_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      burst_q  <= 1'b0;
      cyc_q    <= '0;
      byte_q   <= '0;
      addr_q   <= '0;
      re_q     <= 1'b0;
      vdata_q  <= '0;
      vvalid_q <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      burst_q  <= burst_d;
      cyc_q    <= cyc_d;
      byte_q   <= byte_d;
      addr_q   <= addr_d;
      re_q     <= re_d;
      vdata_q  <= vdata_d;
      vvalid_q <= vvalid_d;
    end
  end

  assign busy    = busy_q;
  assign fl_we   = busy_q && (cyc_q == '0);
  assign fl_re   = re_q;
  assign fl_addr = addr_q;
  assign vdata   = vdata_q;
  assign vvalid  = vvalid_q;

endmodule

// File: rtl/pflash_host_ctrl.sv
module pflash_host_ctrl
  import pfh_pkg::*;
#(
  parameter int ARM_CYCLES  = 32000,
  parameter int BUSY_CYCLES = 640,
  parameter int ROW_BYTES   = 128,
  parameter int LOCK_BLKS   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_rst,
  input  logic                 pin_psen_n,
  input  logic                 pin_strobe_n,
  input  logic [7:0]           p0_in,
  input  logic [7:0]           p1_in,
  input  logic [7:0]           p2_in,
  input  logic [3:0]           p3_hi,
  input  logic [LOCK_BLKS-1:0] blk_lock,
  input  logic [7:0]           fl_rdata,
  output logic [7:0]           p0_out,
  output logic                 p0_oe,
  output logic                 rdy_busy_n,
  output logic                 cpu_rst_o,
  output logic                 osc_en,
  output logic [15:0]          fl_addr,
  output logic [7:0]           fl_wdata,
  output logic                 fl_we,
  output logic                 fl_re
);

  localparam int BB = $clog2(LOCK_BLKS);
  localparam int SW = 3 + 8 + 8 + 8 + 4;

  logic [SW-1:0] pins_s;
  logic          rst_s, psen_n_s, stb_n_s;
  logic [7:0]    p0_s, p1_s, p2_s;
  logic [3:0]    p3_s;

  pfh_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pin_rst, pin_psen_n, pin_strobe_n, p0_in, p1_in, p2_in, p3_hi}),
    .q     (pins_s)
  );

  assign {rst_s, psen_n_s, stb_n_s, p0_s, p1_s, p2_s, p3_s} = pins_s;

  logic        host_q, host_d;
  logic        stb_prev_q;
  logic [15:0] addr;
  logic [3:0]  code;
  op_e         op;
  logic        armed;
  logic        busy;
  logic        lock_hit;
  logic        accept;
  logic        vvalid;
  logic [7:0]  vdata;

  always_comb begin
    host_d = host_q;
    if (!rst_s) begin
      host_d = 1'b0;
    end else if (!psen_n_s) begin
      host_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q     <= 1'b0;
      stb_prev_q <= 1'b0;
    end else begin
      host_q     <= host_d;
      stb_prev_q <= stb_n_s;
    end
  end

  assign addr     = {p3_s[1:0], p2_s[5:0], p1_s};
  assign code     = {p3_s[3:2], p2_s[7:6]};
  assign op       = decode_op(code);
  assign lock_hit = blk_lock[addr[15 -: BB]];
  assign accept   = stb_prev_q && !stb_n_s && host_q && armed && !busy
                    && (op != OP_NONE) && !lock_hit;

  pfh_arm #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .host    (host_q),
    .read_id (is_read_id(code)),
    .armed   (armed)
  );

  pfh_seq #(.BUSY_CYCLES(BUSY_CYCLES), .ROW_BYTES(ROW_BYTES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .op       (op),
    .addr_in  (addr),
    .vclear   (!host_q || (op != OP_VERIFY)),
    .fl_rdata (fl_rdata),
    .busy     (busy),
    .fl_we    (fl_we),
    .fl_re    (fl_re),
    .fl_addr  (fl_addr),
    .vdata    (vdata),
    .vvalid   (vvalid)
  );

  assign fl_wdata   = p0_s;
  assign p0_out     = vdata;
  assign p0_oe      = host_q && vvalid;
  assign rdy_busy_n = !busy;
  assign cpu_rst_o  = rst_s || host_q;
  assign osc_en     = host_q;

endmodule

// File: rtl/pfh_checker.sv
module pfh_checker #(
  parameter int LOCK_BLKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LOCK_BLKS-1:0] blk_lock,
  input logic [15:0]          fl_addr,
  input logic                 fl_we,
  input logic                 fl_re,
  input logic                 rdy_busy_n,
  input logic                 cpu_rst_o,
  input logic                 osc_en,
  input logic                 p0_oe
);

  localparam int BB = $clog2(LOCK_BLKS);

  // R1: the oscillator only runs while the core is held in reset
  a_r1_osc_core_rst: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> cpu_rst_o);

  // R4: writes happen only in host mode
  a_r4_we_in_host: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> osc_en);

  // R5: no write or read reaches a locked block
  a_r5_we_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> !blk_lock[fl_addr[15 -: BB]]);

  a_r5_re_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |-> !blk_lock[fl_addr[15 -: BB]]);

  // R7: write enable is a single-cycle pulse inside a busy period
  a_r7_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |=> !fl_we);

  a_r7_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> !rdy_busy_n);

  // R10: port 0 is driven only in host mode
  a_r10_oe_host: assert property (@(posedge clk) disable iff (!rst_n)
    p0_oe |-> osc_en);

endmodule

bind pflash_host_ctrl pfh_checker #(.LOCK_BLKS(LOCK_BLKS)) u_pfh_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_lock   (blk_lock),
  .fl_addr    (fl_addr),
  .fl_we      (fl_we),
  .fl_re      (fl_re),
  .rdy_busy_n (rdy_busy_n),
  .cpu_rst_o  (cpu_rst_o),
  .osc_en     (osc_en),
  .p0_oe      (p0_oe)
);

// File: tb/pflash_host_ctrl_bench.sv
module pflash_host_ctrl_bench;

  localparam int ARM  = 20;
  localparam int BUSY = 8;
  localparam int ROW  = 4;
  localparam int NBLK = 4;

  logic            clk;
  logic            rst_n;
  logic            pin_rst, pin_psen_n, pin_strobe_n;
  logic [7:0]      p0_in, p1_in, p2_in;
  logic [3:0]      p3_hi;
  logic [NBLK-1:0] blk_lock;
  logic [7:0]      fl_rdata;
  logic [7:0]      p0_out;
  logic            p0_oe, rdy_busy_n, cpu_rst_o, osc_en;
  logic [15:0]     fl_addr;
  logic [7:0]      fl_wdata;
  logic            fl_we, fl_re;

  int checks   = 0;
  int failures = 0;
  int we_cnt   = 0;
  bit done     = 0;

  logic [7:0] mem [logic [15:0]];

  pflash_host_ctrl #(
    .ARM_CYCLES(ARM), .BUSY_CYCLES(BUSY), .ROW_BYTES(ROW), .LOCK_BLKS(NBLK)
  ) u_pflash_host_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_rst(pin_rst), .pin_psen_n(pin_psen_n),
    .pin_strobe_n(pin_strobe_n), .p0_in(p0_in), .p1_in(p1_in), .p2_in(p2_in),
    .p3_hi(p3_hi), .blk_lock(blk_lock), .fl_rdata(fl_rdata), .p0_out(p0_out),
    .p0_oe(p0_oe), .rdy_busy_n(rdy_busy_n), .cpu_rst_o(cpu_rst_o),
    .osc_en(osc_en), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
    .fl_re(fl_re)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural flash array
  always @(posedge clk) begin
    if (fl_we) begin
      mem[fl_addr] = fl_wdata;
      we_cnt = we_cnt + 1;
    end
  end

  always @(*) begin
    fl_rdata = mem.exists(fl_addr) ? mem[fl_addr] : 8'hFF;
  end

  function automatic logic [7:0] peek(input logic [15:0] a);
    peek = mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // code = {P3[7:6], P2[7:6]}
  task automatic set_cmd(input logic [3:0] code);
    p3_hi[3:2] = code[3:2];
    p2_in[7:6] = code[1:0];
  endtask

  task automatic set_addr(input logic [15:0] a);
    p1_in      = a[7:0];
    p2_in[5:0] = a[13:8];
    p3_hi[1:0] = a[15:14];
  endtask

  task automatic strobe();
    pin_strobe_n = 1'b0;
    cyc(2);
    pin_strobe_n = 1'b1;
  endtask

  task automatic measure_busy(output int n);
    int w = 0;
    n = 0;
    while (rdy_busy_n && w < 12) begin
      cyc(1);
      w++;
    end
    while (!rdy_busy_n && n < 200) begin
      cyc(1);
      n++;
    end
  endtask

  task automatic arm();
    set_cmd(4'b0000);
    cyc(ARM + 8);
  endtask

  task automatic t_reset();
    check(cpu_rst_o == 1'b0, "R1 reset cpu_rst", cpu_rst_o, 0);
    check(osc_en == 1'b0, "R1 reset osc_en", osc_en, 0);
    check(rdy_busy_n == 1'b1, "R1 reset ready", rdy_busy_n, 1);
    check(p0_oe == 1'b0 && fl_we == 1'b0, "R1 reset oe/we", {p0_oe, fl_we}, 0);
  endtask

  task automatic t_entry();
    pin_rst = 1'b1;
    cyc(5);
    check(cpu_rst_o == 1'b1, "R1 rst pin holds core", cpu_rst_o, 1);
    check(osc_en == 1'b0, "R1 no host without psen low", osc_en, 0);
    pin_psen_n = 1'b0;
    cyc(5);
    check(osc_en == 1'b1, "R1 host entry osc_en", osc_en, 1);
  endtask

  task automatic t_unarmed();
    int n;
    set_addr(16'h0012);
    p0_in = 8'h5A;
    set_cmd(4'b1110);
    cyc(4);
    strobe();
    measure_busy(n);
    check(n == 0, "R4 unarmed no busy", n, 0);
    check(peek(16'h0012) == 8'hFF, "R4 unarmed no write", peek(16'h0012), 8'hFF);
  endtask

  task automatic t_arm_restart();
    int n;
    set_cmd(4'b0000);
    cyc(12);
    set_cmd(4'b1100);
    cyc(3);
    set_cmd(4'b0000);
    cyc(12);
    set_addr(16'h0013);
    p0_in = 8'h66;
    set_cmd(4'b1110);
    cyc(4);
    strobe();
    measure_busy(n);
    check(peek(16'h0013) == 8'hFF, "R4 broken hold not armed", peek(16'h0013), 8'hFF);
  endtask

  task automatic t_byte();
    int n;
    int w0;
    arm();
    set_addr(16'h1234);
    p0_in = 8'hA5;
    set_cmd(4'b1110);
    cyc(4);
    w0 = we_cnt;
    strobe();
    measure_busy(n);
    check(n == BUSY, "R7 byte busy length", n, BUSY);
    check(we_cnt - w0 == 1, "R7 one write pulse", we_cnt - w0, 1);
    check(peek(16'h1234) == 8'hA5, "R2 R3 byte program data", peek(16'h1234), 8'hA5);
  endtask

  task automatic t_verify();
    set_cmd(4'b1100);
    cyc(4);
    strobe();
    cyc(6);
    check(p0_oe == 1'b1, "R10 verify drives port", p0_oe, 1);
    check(p0_out == 8'hA5, "R10 verify data", p0_out, 8'hA5);
  endtask

  task automatic t_lock();
    int n;
    blk_lock = 4'b0100;
    mem[16'h8123] = 8'h3C;
    set_addr(16'h8124);
    p0_in = 8'h11;
    set_cmd(4'b1110);
    cyc(4);
    strobe();
    measure_busy(n);
    check(n == 0, "R5 locked no busy", n, 0);
    check(peek(16'h8124) == 8'hFF, "R5 locked no write", peek(16'h8124), 8'hFF);
    set_addr(16'h8123);
    set_cmd(4'b1100);
    cyc(4);
    strobe();
    cyc(6);
    check(p0_oe == 1'b0, "R5 locked verify disabled", p0_oe, 0);
    set_addr(16'h4001);
    p0_in = 8'h22;
    set_cmd(4'b1110);
    cyc(4);
    strobe();
    measure_busy(n);
    check(peek(16'h4001) == 8'h22, "R5 unlocked block writes", peek(16'h4001), 8'h22);
    blk_lock = '0;
  endtask

  task automatic t_burst();
    int n;
    set_addr(16'h2346);
    p0_in = 8'h77;
    set_cmd(4'b0110);
    cyc(4);
    strobe();
    measure_busy(n);
    check(n == BUSY * ROW, "R6 burst busy length", n, BUSY * ROW);
    for (int i = 0; i < ROW; i++) begin
      check(peek(16'h2344 + 16'(i)) == 8'h77, "R6 burst row byte",
            peek(16'h2344 + 16'(i)), 8'h77);
    end
    check(peek(16'h2348) == 8'hFF, "R6 burst stays in row", peek(16'h2348), 8'hFF);
  endtask

  task automatic t_busy_ignore();
    int n;
    set_addr(16'h0100);
    p0_in = 8'h5C;
    set_cmd(4'b1110);
    cyc(4);
    strobe();
    cyc(2);
    set_addr(16'h0200);
    cyc(1);
    strobe();
    cyc(BUSY + 8);
    check(peek(16'h0100) == 8'h5C, "R8 first write lands", peek(16'h0100), 8'h5C);
    check(peek(16'h0200) == 8'hFF, "R8 strobe while busy ignored", peek(16'h0200), 8'hFF);
  endtask

  task automatic t_exit();
    int n;
    pin_rst = 1'b0;
    cyc(5);
    check(osc_en == 1'b0 && cpu_rst_o == 1'b0, "R1 host exit",
          {osc_en, cpu_rst_o}, 0);
    check(p0_oe == 1'b0, "R10 exit releases port", p0_oe, 0);
    pin_rst = 1'b1;
    cyc(5);
    set_addr(16'h0300);
    p0_in = 8'h99;
    set_cmd(4'b1110);
    cyc(4);
    strobe();
    measure_busy(n);
    check(peek(16'h0300) == 8'hFF, "R9 re-entry needs arming", peek(16'h0300), 8'hFF);
    arm();
    set_cmd(4'b1110);
    cyc(4);
    strobe();
    measure_busy(n);
    check(peek(16'h0300) == 8'h99, "R9 re-armed write", peek(16'h0300), 8'h99);
  endtask

  initial begin
    rst_n = 1'b0;
    pin_rst = 1'b0;
    pin_psen_n = 1'b1;
    pin_strobe_n = 1'b1;
    p0_in = '0;
    p1_in = '0;
    p2_in = '0;
    p3_hi = '0;
    blk_lock = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_entry();
    t_unarmed();
    t_arm_restart();
    t_byte();
    t_verify();
    t_lock();
    t_burst();
    t_busy_ignore();
    t_exit();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule